// File: doc/BRIEF.md
# DRAM Initialisation and CAS-before-RAS Refresh Controller

This block brings an EDO DRAM out of power-up and then keeps its contents alive. After reset it waits a programmable pause of at least 200 µs. It then runs a fixed burst of CAS-before-RAS (CBR) refresh cycles. Only after that burst does it declare the memory usable. From then on, a free-running interval timer adds one owed refresh per period. The period is set a little under 15.6 µs, so that 4096 rows are covered well inside 64 ms.

The controller does not own the memory bus. For every refresh it raises a request and waits for a grant from the system arbiter. It then drives the row strobe, column strobe and write-enable strobe through the CBR sequence. Column strobe falls first. Row strobe follows, both are held low, both rise, and a precharge interval follows. At the end it drops its request for one cycle and pulses a completion flag. No address is driven, because the device steps its own internal row counter. Refreshes that cannot be granted at once are counted in a saturating owed counter, so a long access burst can postpone several of them. Write-enable is never asserted, so the data pins stay in high impedance throughout.

Top module: `cbr_refresh_ctrl`

## Requirements
- R1: After reset is released, `refReq` stays low and all strobes stay high while the pause runs. The first `refReq` is high after exactly PAUSE_CYC+1 rising edges.
- R2: Exactly INIT_CNT refreshes follow the pause. `initDone` is low during all of them, including the completion cycle of the last one. It is high from the next cycle onward.
- R3: Each refresh drives `casN` low alone for CSR_CYC cycles, then `rasN` and `casN` together low for RAS_CYC cycles. Both then rise together, and both stay high for RP_CYC precharge cycles before completion. `rasN` is never low while `casN` is high.
- R4: `weN` is high in every cycle, so the device never sees a write and keeps its outputs in high impedance.
- R5: `refReq` holds until the refresh it asks for completes. While `refGnt` is low, no strobe moves. `casN` falls in the cycle after `refGnt` is sampled high with `refReq` high. `refReq` drops only in the completion cycle.
- R6: `refDone` is a single-cycle pulse per completed refresh. It coincides with `refReq` low, and no strobe is low outside an active request.
- R7: After `initDone` rises, the first periodic request appears INTERVAL_CYC+1 cycles later. When grants are immediate, later completions are exactly INTERVAL_CYC cycles apart.
- R8: Owed refreshes saturate at MAX_OWED. While the grant is withheld, no refresh runs. Once the grant is given, after many periods without one, exactly MAX_OWED back-to-back refreshes run and the request then goes quiet.
- R9: Asserting `rstN` low at any point, including mid-refresh, immediately returns all strobes high, `refReq` low and `initDone` low. The pause then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refGnt | input | 1 | Bus grant from the arbiter |
| refReq | output | 1 | Bus request for a refresh cycle |
| refDone | output | 1 | One-cycle pulse when a refresh completes |
| initDone | output | 1 | High once the pause and initial refreshes are complete |
| rasN | output | 1 | Row strobe to the DRAM, active low |
| casN | output | 1 | Column strobe to the DRAM (both byte lanes), active low |
| weN | output | 1 | Write enable to the DRAM, active low, held inactive |

## Verification
A corrupted phase counter or state shows up at once at the strobe pins. The CAS-only lead, the RAS-low width or the precharge gap changes length within the same refresh, and the bench measures each of them cycle by cycle. A wrong pause, interval or initial-refresh counter is seen at the first request edge, or at the rise of `initDone`, which the bench timestamps exactly. A bad owed counter becomes visible only after a grant is withheld for several periods and then given. The length of the resulting burst reveals it.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_REQ,
    ST_CSR,
    ST_RAS,
    ST_PRE,
    ST_DONE
  } refState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic phaseClr;
    logic initStep;
    logic owedTake;
  } refCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic pauseOver;
    logic initLast;
    logic initOver;
    logic owedAny;
    logic csrEnd;
    logic rasEnd;
    logic preEnd;
  } refSts_t;

endpackage

// File: rtl/cbr_refresh_dp.sv
module cbr_refresh_dp
  import cbr_refresh_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int INTERVAL_CYC = 1900,
  parameter int INIT_CNT     = 8,
  parameter int MAX_OWED     = 8,
  parameter int CSR_CYC      = 1,
  parameter int RAS_CYC      = 8,
  parameter int RP_CYC       = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  refCtl_t ctl,
  output refSts_t sts
);

  localparam int PAUSE_W = $clog2(PAUSE_CYC + 1);
  localparam int IVL_W   = $clog2(INTERVAL_CYC);
  localparam int INIT_W  = $clog2(INIT_CNT + 1);
  localparam int OWED_W  = $clog2(MAX_OWED + 1);
  localparam int PH_A    = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int PH_LONG = (PH_A > RP_CYC) ? PH_A : RP_CYC;
  localparam int PH_W    = $clog2(PH_LONG + 1);
  localparam int PH_LIM [3] = '{CSR_CYC, RAS_CYC, RP_CYC};

  localparam logic [PAUSE_W-1:0] PAUSE_END = PAUSE_W'(PAUSE_CYC);
  localparam logic [IVL_W-1:0]   IVL_LAST  = IVL_W'(INTERVAL_CYC - 1);
  localparam logic [INIT_W-1:0]  INIT_END  = INIT_W'(INIT_CNT);
  localparam logic [INIT_W-1:0]  INIT_PEN  = INIT_W'(INIT_CNT - 1);
  localparam logic [OWED_W-1:0]  OWED_TOP  = OWED_W'(MAX_OWED);
  localparam logic [PH_W-1:0]    PH_TOP    = PH_W'(PH_LONG);

  logic [PAUSE_W-1:0] pauseCnt;
  logic [IVL_W-1:0]   ivlCnt;
  logic [INIT_W-1:0]  initCnt;
  logic [OWED_W-1:0]  owed;
  logic [PH_W-1:0]    phaseCnt;
  logic [2:0]         phEnd;
  logic               initOver;
  logic               tick;

  assign initOver = (initCnt == INIT_END);
  assign tick     = initOver && (ivlCnt == IVL_LAST);

  // power-up pause, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   pauseCnt <= '0;
    else if (pauseCnt != PAUSE_END) pauseCnt <= pauseCnt + 1'b1;
  end

  // strobe phase timer, restarted by control at each phase entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (ctl.phaseClr)     phaseCnt <= '0;
    else if (phaseCnt != PH_TOP) phaseCnt <= phaseCnt + 1'b1;
  end

  for (genvar g = 0; g < 3; g++) begin : gPhEnd
    assign phEnd[g] = (phaseCnt == PH_W'(PH_LIM[g] - 1));
  end

  // initial refresh count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         initCnt <= '0;
    else if (ctl.initStep && !initOver) initCnt <= initCnt + 1'b1;
  end

  // refresh interval timer, free-running once initialised
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ivlCnt <= '0;
    else if (!initOver)        ivlCnt <= '0;
    else if (ivlCnt == IVL_LAST) ivlCnt <= '0;
    else                       ivlCnt <= ivlCnt + 1'b1;
  end

  // owed refreshes, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      owed <= '0;
    else if (tick && !ctl.owedTake && owed != OWED_TOP) owed <= owed + 1'b1;
    else if (ctl.owedTake && !tick)                 owed <= owed - 1'b1;
  end

  assign sts.pauseOver = (pauseCnt == PAUSE_END);
  assign sts.initLast  = (initCnt == INIT_PEN);
  assign sts.initOver  = initOver;
  assign sts.owedAny   = (owed != '0);
  assign sts.csrEnd    = phEnd[0];
  assign sts.rasEnd    = phEnd[1];
  assign sts.preEnd    = phEnd[2];

  assert_owed_cap_R8: assert property (@(posedge clk) disable iff (!rstN)
    owed <= OWED_TOP);

  assert_take_has_owed_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.owedTake |-> owed != '0);

  assert_init_after_pause_R2: assert property (@(posedge clk) disable iff (!rstN)
    initOver |-> sts.pauseOver);

endmodule

// File: rtl/cbr_refresh_ctl.sv
module cbr_refresh_ctl
  import cbr_refresh_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    refGnt,
  input  refSts_t sts,
  output refCtl_t ctl,
  output logic    refReq,
  output logic    refDone,
  output logic    rasN,
  output logic    casN,
  output logic    weN
);

  refState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PAUSE;
    else       state <= nextState;
  end

  always_comb begin
    nextState    = state;
    ctl          = '0;
    unique case (state)
      ST_PAUSE: if (sts.pauseOver) nextState = ST_REQ;
      ST_IDLE:  if (sts.owedAny)   nextState = ST_REQ;
      ST_REQ: if (refGnt) begin
        nextState    = ST_CSR;
        ctl.phaseClr = 1'b1;
      end
      ST_CSR: if (sts.csrEnd) begin
        nextState    = ST_RAS;
        ctl.phaseClr = 1'b1;
      end
      ST_RAS: if (sts.rasEnd) begin
        nextState    = ST_PRE;
        ctl.phaseClr = 1'b1;
      end
      ST_PRE: if (sts.preEnd) nextState = ST_DONE;
      ST_DONE: begin
        if (!sts.initOver) begin
          ctl.initStep = 1'b1;
          nextState    = sts.initLast ? ST_IDLE : ST_REQ;
        end else begin
          ctl.owedTake = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_PAUSE;
    endcase
  end

  assign refReq  = (state == ST_REQ) || (state == ST_CSR) ||
                   (state == ST_RAS) || (state == ST_PRE);
  assign refDone = (state == ST_DONE);
  assign casN    = !((state == ST_CSR) || (state == ST_RAS));
  assign rasN    = !(state == ST_RAS);
  assign weN     = 1'b1;

  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> $past(!casN));

  assert_grant_before_cas_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> $past(refGnt && refReq));

  assert_req_drop_on_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refReq) |-> refDone);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    refDone |=> !refDone);

endmodule

// File: rtl/cbr_refresh_ctrl.sv
module cbr_refresh_ctrl
  import cbr_refresh_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int INTERVAL_CYC = 1900,
  parameter int INIT_CNT     = 8,
  parameter int MAX_OWED     = 8,
  parameter int CSR_CYC      = 1,
  parameter int RAS_CYC      = 8,
  parameter int RP_CYC       = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGnt,
  output logic refReq,
  output logic refDone,
  output logic initDone,
  output logic rasN,
  output logic casN,
  output logic weN
);

  refCtl_t ctl;
  refSts_t sts;

  cbr_refresh_dp #(
    .PAUSE_CYC(PAUSE_CYC), .INTERVAL_CYC(INTERVAL_CYC), .INIT_CNT(INIT_CNT),
    .MAX_OWED(MAX_OWED), .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sts(sts)
  );

  cbr_refresh_ctl i_ctl (
    .clk(clk), .rstN(rstN), .refGnt(refGnt), .sts(sts), .ctl(ctl),
    .refReq(refReq), .refDone(refDone), .rasN(rasN), .casN(casN), .weN(weN)
  );

  assign initDone = sts.initOver;

endmodule

// File: tb/test_cbr_refresh_ctrl.sv
`timescale 1ns/1ps
module test_cbr_refresh_ctrl;

  localparam int PAUSE    = 40;
  localparam int INTERVAL = 200;
  localparam int INIT     = 8;
  localparam int OWEDMAX  = 3;
  localparam int CSR      = 2;
  localparam int RAS      = 8;
  localparam int RP       = 5;

  // {grant delay, expected initDone after this refresh}
  localparam logic [8:0] VEC [INIT] = '{
    {8'd0, 1'b0}, {8'd1, 1'b0}, {8'd3, 1'b0}, {8'd0, 1'b0},
    {8'd7, 1'b0}, {8'd2, 1'b0}, {8'd5, 1'b0}, {8'd1, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGnt = 1'b0;
  logic refReq, refDone, initDone, rasN, casN, weN;

  int checks = 0;
  int errors = 0;
  bit autoGrant = 1'b0;
  bit finished = 1'b0;
  int sinceInit = 0;
  int weBad = 0, orderBad = 0, strayBad = 0, doneBad = 0;

  always #4 clk = ~clk;

  cbr_refresh_ctrl #(
    .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTERVAL), .INIT_CNT(INIT),
    .MAX_OWED(OWEDMAX), .CSR_CYC(CSR), .RAS_CYC(RAS), .RP_CYC(RP)
  ) i_cbr_refresh_ctrl (
    .clk(clk), .rstN(rstN), .refGnt(refGnt), .refReq(refReq),
    .refDone(refDone), .initDone(initDone), .rasN(rasN), .casN(casN), .weN(weN)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic measurePause(input string req);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!refReq && k < 4 * PAUSE);
    chkEq(req, k, PAUSE + 1);
  endtask

  task automatic grantedCycle(input int delay, input bit expInit);
    int n = 0;
    while (!refReq && n < 1000) begin @(negedge clk); n++; end
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      chkEq("R5 strobes idle before grant", {rasN, casN, refReq}, 3'b111);
    end
    refGnt = 1'b1;
    @(negedge clk);
    n = 0;
    while (!casN && rasN && n < 50) begin n++; @(negedge clk); end
    chkEq("R3 CAS-only lead cycles", n, CSR);
    n = 0;
    while (!casN && !rasN && n < 50) begin n++; @(negedge clk); end
    chkEq("R3 RAS-low cycles", n, RAS);
    n = 0;
    while (casN && rasN && refReq && n < 50) begin n++; @(negedge clk); end
    chkEq("R3 precharge cycles", n, RP);
    chkEq("R6 done pulse", refDone, 1);
    chkEq("R5 request released in done cycle", refReq, 0);
    chkEq("R2 initDone low in done cycle", initDone, 0);
    refGnt = 1'b0;
    @(negedge clk);
    chkEq("R6 done is single cycle", refDone, 0);
    chkEq("R2 initDone after refresh", initDone, expInit);
  endtask

  initial begin
    int j;
    int doneAt [5];
    int cnt;
    int quiet;

    fork
      begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
      end
      forever begin : arbiter
        @(negedge clk);
        if (autoGrant) refGnt = refReq;
      end
      forever begin : monitor
        @(negedge clk);
        if (rstN) begin
          if (!weN) weBad++;
          if (!rasN && casN) orderBad++;
          if ((!rasN || !casN) && !refReq) strayBad++;
          if (refDone && refReq) doneBad++;
        end
        sinceInit = initDone ? sinceInit + 1 : 0;
      end
    join_none

    // reset state
    repeat (3) @(negedge clk);
    chkEq("R9 reset rasN", rasN, 1);
    chkEq("R9 reset casN", casN, 1);
    chkEq("R4 reset weN", weN, 1);
    chkEq("R9 reset refReq", refReq, 0);
    chkEq("R9 reset initDone", initDone, 0);
    chkEq("R6 reset refDone", refDone, 0);

    // R1: power-up pause
    rstN = 1'b1;
    measurePause("R1 first request after pause");

    // R2/R3/R5: initial refreshes, table driven
    for (int v = 0; v < INIT; v++)
      grantedCycle(int'(VEC[v][8:1]), VEC[v][0]);

    // R7: first periodic request
    j = 0;
    while (!refReq && j < 4 * INTERVAL) begin @(negedge clk); j++; end
    chkEq("R7 first periodic request latency", j, INTERVAL + 1);

    // R7: steady spacing with immediate grants
    autoGrant = 1'b1;
    j = 0;
    for (int d = 0; d < 5; d++) begin
      do begin @(negedge clk); j++; end while (!refDone && j < 20 * INTERVAL);
      doneAt[d] = j;
    end
    for (int d = 2; d < 5; d++)
      chkEq("R7 refresh spacing", doneAt[d] - doneAt[d-1], INTERVAL);

    // R8: withhold grant across many periods
    autoGrant = 1'b0;
    refGnt = 1'b0;
    cnt = 0;
    repeat (5 * INTERVAL) begin
      @(negedge clk);
      if (refDone) cnt++;
      if (!casN || !rasN) cnt++;
    end
    chkEq("R8 no refresh activity without grant", cnt, 0);
    chkEq("R5 request held while grant withheld", refReq, 1);
    j = 0;
    while ((sinceInit % INTERVAL) != INTERVAL / 4 && j < 2 * INTERVAL) begin
      @(negedge clk); j++;
    end
    autoGrant = 1'b1;
    cnt = 0;
    quiet = 0;
    for (int t = 0; t < 600 && quiet < 6; t++) begin
      @(negedge clk);
      if (refDone) cnt++;
      if (refReq || refDone) quiet = 0;
      else quiet++;
    end
    chkEq("R8 saturated owed burst length", cnt, OWEDMAX);

    // R9: reset in the middle of a refresh
    j = 0;
    while (casN && j < 4 * INTERVAL) begin @(negedge clk); j++; end
    chkEq("R9 refresh in progress before reset", casN, 0);
    autoGrant = 1'b0;
    refGnt = 1'b0;
    rstN = 1'b0;
    #1;
    chkEq("R9 mid-refresh reset strobes", {rasN, casN, weN}, 3'b111);
    chkEq("R9 mid-refresh reset refReq", refReq, 0);
    chkEq("R9 mid-refresh reset initDone", initDone, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    measurePause("R9 pause restarts after reset");

    // protocol invariants accumulated over the run
    chkEq("R4 weN never asserted", weBad, 0);
    chkEq("R3 rasN low without casN", orderBad, 0);
    chkEq("R6 strobe outside request", strayBad, 0);
    chkEq("R6 done overlapping request", doneBad, 0);

    summary();
  end

endmodule